// File: doc/BRIEF.md
# Coarse-Grain Thread Switch Controller

This block decides which of several hardware thread contexts owns a short in-order pipeline. One context is configured as the preferred thread and runs whenever it can. When the running thread reports the start of a long-latency (second-level) miss, the controller hands the pipeline to another context that is ready and not itself waiting on a miss. When the preferred thread's miss returns, the controller takes the pipeline back for it. If no context is available, fetch is held idle.

The pipeline is not partitioned between threads. Every change of owner raises a one-cycle flush pulse, which discards everything in flight. In that same cycle a one-hot redirect select names the incoming thread, so fetch restarts from that thread's saved PC. Program counters and register files are kept per thread outside this block. Arithmetic units and caches are shared outside this block.

Miss-start and miss-return events arrive as a valid bit plus a thread id. Each context also has a ready flag, which marks it as runnable. All state changes happen at the rising clock edge, and the outputs are registered.

Top module: `cgmt_thread_switch`

## Requirements
- R1: In the first cycle after a synchronous active-low reset the following hold: `act_tid` equals `pref_tid`, `fetch_vld` is 1, `flush` is 0, `redir_sel` is 0, and no thread is recorded as waiting on a miss.
- R2: A miss start from the running thread records that thread as waiting. If another thread is then ready and not waiting, it becomes `act_tid` after the next edge. The preferred thread wins when it is available. Otherwise the lowest-numbered available thread wins.
- R3: A miss return for a thread clears its waiting record. Once the preferred thread is ready and not waiting, it replaces a non-preferred running thread at the next edge.
- R4: Each change of `act_tid` raises `flush` for exactly one cycle, in the same cycle as the new `act_tid`. `redir_sel` is one-hot with bit `act_tid` set during that cycle, and it is all zero in every other cycle.
- R5: When no thread is both ready and not waiting, `fetch_vld` drops to 0. In that case `act_tid` keeps its value and no flush is raised.
- R6: A miss start whose thread id differs from `act_tid` is ignored. So is any miss start while `fetch_vld` is 0. Neither one records a miss.
- R7: In a cycle where `flush` is 1, no new switch is decided. Miss events in that cycle still update the waiting records, and a switch they call for appears one cycle later.
- R8: A thread whose `thr_ready` bit is 0 is never chosen as the incoming thread.
- R9: Leaving the idle state back to the same thread sets `fetch_vld` to 1 without a flush. Leaving it to a different thread flushes as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| pref_tid | input | TW | Preferred thread id (configuration, static between resets) |
| thr_ready | input | NTHR | Per-thread runnable flag |
| miss_st_vld | input | 1 | Long-latency miss start event valid |
| miss_st_tid | input | TW | Thread id of the miss start |
| miss_rt_vld | input | 1 | Miss return event valid |
| miss_rt_tid | input | TW | Thread id of the miss return |
| act_tid | output | TW | Thread currently owning the pipeline |
| fetch_vld | output | 1 | Fetch enabled for `act_tid`; 0 while idle |
| flush | output | 1 | One-cycle pipeline flush on a switch |
| redir_sel | output | NTHR | One-hot select of the saved PC to refetch from, only during flush |

## Verification
The key coincidence is a miss event landing in the flush cycle of a switch that has just happened. For example, the preferred thread's return can arrive while the pipeline is still flushing into the secondary thread. A directed case times the return into that cycle. It then checks that the owner holds for one more cycle and that a second one-cycle flush back to the preferred thread follows. A second coincidence is a return and a start arriving in the same cycle. The random phase drives both events every cycle at high rates and compares every output against a bench model computed from the requirements.

// File: rtl/cgmt_pkg.sv
// Package: shared decision encoding for the coarse-grain thread switch
// controller. Assumes nothing beyond standard SystemVerilog.
package cgmt_pkg;

    // Outcome of one scheduling evaluation.
    typedef enum logic [1:0] {
        DEC_KEEP   = 2'd0,  // same thread keeps (or resumes) the pipeline
        DEC_SWITCH = 2'd1,  // another thread takes over, flush required
        DEC_IDLE   = 2'd2,  // nobody available, fetch held off
        DEC_HOLD   = 2'd3   // flush in progress, no decision this cycle
    } dec_e;

endpackage

// File: rtl/cgmt_miss_track.sv
// Module: cgmt_miss_track
// Keeps one "waiting on a long-latency miss" bit per thread. A miss start
// is accepted only from the thread that is running with fetch enabled.
// A return clears the bit of its thread. Also provides the next-state view,
// so the scheduler can decide in the same cycle as the events.
// Assumes: at most one start and one return event per cycle.
module cgmt_miss_track #(
    parameter int NTHR = 2,
    localparam int TW  = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            st_vld,
    input  logic [TW-1:0]   st_tid,
    input  logic            rt_vld,
    input  logic [TW-1:0]   rt_tid,
    input  logic [TW-1:0]   act_tid,
    input  logic            run,
    output logic [NTHR-1:0] pend_q,
    output logic [NTHR-1:0] pend_nxt
);

    logic [NTHR-1:0] st_hit;
    logic [NTHR-1:0] rt_hit;

    // Decode event ids into per-thread hit vectors; starts filtered to runner.
    always_comb begin
        st_hit = '0;
        rt_hit = '0;
        for (int i = 0; i < NTHR; i++) begin
            st_hit[i] = st_vld && run && (st_tid == act_tid) && (st_tid == TW'(i));
            rt_hit[i] = rt_vld && (rt_tid == TW'(i));
        end
    end

    // Next waiting bits: a start sets, a return clears (start wins on clash).
    always_comb begin
        pend_nxt = (pend_q & ~rt_hit) | st_hit;
    end

    // Waiting-bit register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_nxt;
    end

    // R6: a start from a thread other than the runner leaves its bit alone
    assert_ignore_foreign_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_vld && (st_tid != act_tid) && !(rt_vld && rt_tid == st_tid))
        |=> (pend_q[$past(st_tid)] == $past(pend_q[st_tid])));

endmodule

// File: rtl/cgmt_pick.sv
// Module: cgmt_pick
// Combinational choice of the thread that should own the pipeline. The
// preferred thread wins if it is ready and not waiting. Otherwise the
// lowest-numbered available thread wins. tgt_vld is 0 when no thread is
// available. Assumes pref_tid < NTHR.
module cgmt_pick #(
    parameter int NTHR = 2,
    localparam int TW  = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic [NTHR-1:0] ready,
    input  logic [NTHR-1:0] pend_nxt,
    input  logic [TW-1:0]   pref_tid,
    output logic            tgt_vld,
    output logic [TW-1:0]   tgt_tid
);

    logic [NTHR-1:0] avail;

    // Available = runnable and not waiting on a miss.
    always_comb avail = ready & ~pend_nxt;

    // Priority pick: preferred first, then lowest index.
    always_comb begin
        tgt_vld = 1'b0;
        tgt_tid = pref_tid;
        if (avail[pref_tid]) begin
            tgt_vld = 1'b1;
        end else begin
            for (int i = NTHR - 1; i >= 0; i--) begin
                if (avail[i]) begin
                    tgt_vld = 1'b1;
                    tgt_tid = TW'(i);
                end
            end
        end
    end

endmodule

// File: rtl/cgmt_own_ctrl.sv
// Module: cgmt_own_ctrl
// Holds the owning thread, the fetch-enable bit and the one-cycle flush
// pulse. It applies the pick result unless a flush is in progress, in which
// case the state is held for that cycle. The redirect select is the one-hot
// incoming thread, driven only in the flush cycle.
// Assumes pref_tid is static between resets.
module cgmt_own_ctrl
    import cgmt_pkg::*;
#(
    parameter int NTHR = 2,
    localparam int TW  = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TW-1:0]   pref_tid,
    input  logic            tgt_vld,
    input  logic [TW-1:0]   tgt_tid,
    input  logic [NTHR-1:0] pend_q,
    output logic [TW-1:0]   act_tid,
    output logic            run,
    output logic            flush,
    output logic [NTHR-1:0] redir_sel
);

    dec_e dec;

    // Classify this cycle's outcome from the pick and the flush state.
    always_comb begin
        if (flush)                  dec = DEC_HOLD;
        else if (!tgt_vld)          dec = DEC_IDLE;
        else if (tgt_tid != act_tid) dec = DEC_SWITCH;
        else                        dec = DEC_KEEP;
    end

    // Owner, fetch enable and flush registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_tid <= pref_tid;
            run     <= 1'b1;
            flush   <= 1'b0;
        end else begin
            unique case (dec)
                DEC_HOLD: begin
                    flush <= 1'b0;
                end
                DEC_IDLE: begin
                    run   <= 1'b0;
                    flush <= 1'b0;
                end
                DEC_SWITCH: begin
                    act_tid <= tgt_tid;
                    run     <= 1'b1;
                    flush   <= 1'b1;
                end
                default: begin
                    run   <= 1'b1;
                    flush <= 1'b0;
                end
            endcase
        end
    end

    // One-hot redirect select toward the incoming thread during flush only.
    always_comb begin
        redir_sel = '0;
        if (flush) redir_sel[act_tid] = 1'b1;
    end

    // R4: flush never lasts two cycles
    assert_flush_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !flush);

    // R4: redirect select is one-hot in flush, empty otherwise
    assert_redir_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(redir_sel) == (flush ? 1 : 0)));

    // R7: owner does not change in the cycle after a flush starts
    assert_hold_in_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> $stable(act_tid));

    // R2: the thread switched in was not waiting on a miss
    assert_switch_target_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !pend_q[act_tid]);

endmodule

// File: rtl/cgmt_thread_switch.sv
// Module: cgmt_thread_switch (top)
// Coarse-grain thread switch controller. It hands a single in-order pipeline
// between NTHR contexts on long-latency misses, with a preferred thread and
// a flush on every switch. Assumes pref_tid is static between resets and
// that at most one miss start and one miss return arrive per cycle.
module cgmt_thread_switch #(
    parameter int NTHR = 2,
    localparam int TW  = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TW-1:0]   pref_tid,
    input  logic [NTHR-1:0] thr_ready,
    input  logic            miss_st_vld,
    input  logic [TW-1:0]   miss_st_tid,
    input  logic            miss_rt_vld,
    input  logic [TW-1:0]   miss_rt_tid,
    output logic [TW-1:0]   act_tid,
    output logic            fetch_vld,
    output logic            flush,
    output logic [NTHR-1:0] redir_sel
);

    logic [NTHR-1:0] pend_q;
    logic [NTHR-1:0] pend_nxt;
    logic            tgt_vld;
    logic [TW-1:0]   tgt_tid;

    cgmt_miss_track #(.NTHR(NTHR)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .st_vld   (miss_st_vld),
        .st_tid   (miss_st_tid),
        .rt_vld   (miss_rt_vld),
        .rt_tid   (miss_rt_tid),
        .act_tid  (act_tid),
        .run      (fetch_vld),
        .pend_q   (pend_q),
        .pend_nxt (pend_nxt)
    );

    cgmt_pick #(.NTHR(NTHR)) u_pick (
        .ready    (thr_ready),
        .pend_nxt (pend_nxt),
        .pref_tid (pref_tid),
        .tgt_vld  (tgt_vld),
        .tgt_tid  (tgt_tid)
    );

    cgmt_own_ctrl #(.NTHR(NTHR)) u_own (
        .clk       (clk),
        .rst_n     (rst_n),
        .pref_tid  (pref_tid),
        .tgt_vld   (tgt_vld),
        .tgt_tid   (tgt_tid),
        .pend_q    (pend_q),
        .act_tid   (act_tid),
        .run       (fetch_vld),
        .flush     (flush),
        .redir_sel (redir_sel)
    );

    // R5: idle never coincides with a flush
    assert_idle_no_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_vld |-> !flush);

endmodule

// File: tb/sim_cgmt_thread_switch.sv
// Bench for cgmt_thread_switch with NTHR = 2. It runs directed corner cases
// and then seeded random traffic. The outputs are compared with a bench
// model built from the requirements.
module sim_cgmt_thread_switch;
    localparam int CLK_PERIOD = 10;
    localparam int NTHR = 2;
    localparam int TW = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [TW-1:0] pref_tid = '0;
    logic [NTHR-1:0] thr_ready = '1;
    logic miss_st_vld = 1'b0, miss_rt_vld = 1'b0;
    logic [TW-1:0] miss_st_tid = '0, miss_rt_tid = '0;
    logic [TW-1:0] act_tid;
    logic fetch_vld, flush;
    logic [NTHR-1:0] redir_sel;

    int total = 0, bad = 0;
    bit done = 0;

    // model state
    logic [TW-1:0] m_act = '0;
    logic m_run = 1'b1, m_fl = 1'b0;
    logic [NTHR-1:0] m_pend = '0;
    logic [TW-1:0] n_act;
    logic n_run, n_fl;
    logic [NTHR-1:0] n_pend;

    always #(CLK_PERIOD/2) clk = ~clk;

    cgmt_thread_switch #(.NTHR(NTHR)) u0 (
        .clk(clk), .rst_n(rst_n), .pref_tid(pref_tid), .thr_ready(thr_ready),
        .miss_st_vld(miss_st_vld), .miss_st_tid(miss_st_tid),
        .miss_rt_vld(miss_rt_vld), .miss_rt_tid(miss_rt_tid),
        .act_tid(act_tid), .fetch_vld(fetch_vld), .flush(flush), .redir_sel(redir_sel)
    );

    function automatic logic [NTHR-1:0] exp_redir(input logic fl, input logic [TW-1:0] a);
        return fl ? (NTHR'(1) << a) : '0;
    endfunction

    // Next model state from the requirements, for the current inputs.
    task automatic model_next();
        logic [NTHR-1:0] sth, rth, av;
        logic [TW-1:0] oth;
        n_act = m_act; n_run = m_run; n_fl = 1'b0;
        if (!rst_n) begin
            n_act = pref_tid; n_run = 1'b1; n_pend = '0;
            return;
        end
        sth = (miss_st_vld && m_run && miss_st_tid == m_act) ? (NTHR'(1) << miss_st_tid) : '0;
        rth = miss_rt_vld ? (NTHR'(1) << miss_rt_tid) : '0;
        n_pend = (m_pend & ~rth) | sth;
        if (m_fl) return;
        av = thr_ready & ~n_pend;
        oth = pref_tid ^ 1'b1;
        if (av[pref_tid] || av[oth]) begin
            logic [TW-1:0] t;
            t = av[pref_tid] ? pref_tid : oth;
            n_run = 1'b1;
            if (t != m_act) begin n_act = t; n_fl = 1'b1; end
        end else begin
            n_run = 1'b0;
        end
    endtask

    task automatic chk(input string tag, input string what, input int act_v, input int exp_v);
        total++;
        if (act_v != exp_v) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act_v, exp_v, $time);
        end
    endtask

    // Compare all outputs with the model; act field carries the given tag.
    task automatic cmp_all(input string tag);
        chk(tag, "act_tid", act_tid, m_act);
        chk("R5", "fetch_vld", fetch_vld, m_run);
        chk("R4", "flush", flush, m_fl);
        chk("R4", "redir_sel", redir_sel, exp_redir(m_fl, m_act));
    endtask

    // Drive one cycle of inputs at negedge, advance the model, sample at the next negedge.
    task automatic step(input logic rn, input logic sv, input logic [TW-1:0] st,
                        input logic rv, input logic [TW-1:0] rt, input logic [NTHR-1:0] rdy);
        rst_n = rn; miss_st_vld = sv; miss_st_tid = st;
        miss_rt_vld = rv; miss_rt_tid = rt; thr_ready = rdy;
        model_next();
        @(posedge clk);
        m_act = n_act; m_run = n_run; m_fl = n_fl; m_pend = n_pend;
        @(negedge clk);
    endtask

    task automatic idle_cyc();
        step(1'b1, 1'b0, '0, 1'b0, '0, 2'b11);
    endtask

    initial begin
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        @(negedge clk);
        pref_tid = 1'b0;
        step(1'b0, 1'b0, '0, 1'b0, '0, 2'b11);
        // R1: reset state
        chk("R1", "act_tid", act_tid, 0);
        chk("R1", "fetch_vld", fetch_vld, 1);
        chk("R1", "flush", flush, 0);
        chk("R1", "redir_sel", redir_sel, 0);
        // R6: start from non-active thread 1 is ignored
        step(1'b1, 1'b1, 1'b1, 1'b0, '0, 2'b11);
        chk("R6", "act_tid", act_tid, 0);
        chk("R6", "flush", flush, 0);
        // R2: preferred misses -> thread 1 (proves 1 was not recorded as waiting)
        step(1'b1, 1'b1, 1'b0, 1'b0, '0, 2'b11);
        chk("R2", "act_tid", act_tid, 1);
        chk("R4", "flush", flush, 1);
        chk("R4", "redir_sel", redir_sel, 2);
        // R7: return of thread 0 in the flush cycle is held one cycle
        step(1'b1, 1'b0, '0, 1'b1, 1'b0, 2'b11);
        chk("R7", "act_tid", act_tid, 1);
        chk("R7", "flush", flush, 0);
        idle_cyc();
        chk("R3", "act_tid", act_tid, 0);
        chk("R3", "flush", flush, 1);
        chk("R4", "redir_sel", redir_sel, 1);
        idle_cyc();
        chk("R4", "flush", flush, 0);
        // R8: thread 1 not ready -> preferred miss leads to idle
        step(1'b1, 1'b1, 1'b0, 1'b0, '0, 2'b01);
        chk("R8", "act_tid", act_tid, 0);
        chk("R8", "fetch_vld", fetch_vld, 0);
        chk("R5", "flush", flush, 0);
        // R6: start while idle ignored; R9: thread 1 becomes ready -> switch with flush
        step(1'b1, 1'b1, 1'b1, 1'b0, '0, 2'b11);
        chk("R9", "act_tid", act_tid, 1);
        chk("R9", "flush", flush, 1);
        idle_cyc();
        // R5: thread 1 also misses -> idle
        step(1'b1, 1'b1, 1'b1, 1'b0, '0, 2'b11);
        chk("R5", "fetch_vld", fetch_vld, 0);
        chk("R5", "act_tid", act_tid, 1);
        // R9: thread 1 returns -> resume same thread, no flush
        step(1'b1, 1'b0, '0, 1'b1, 1'b1, 2'b11);
        chk("R9", "fetch_vld", fetch_vld, 1);
        chk("R9", "flush", flush, 0);
        // R3: thread 0 returns -> back to preferred
        step(1'b1, 1'b0, '0, 1'b1, 1'b0, 2'b11);
        chk("R3", "act_tid", act_tid, 0);
        chk("R3", "flush", flush, 1);
        // Preferred = 1 after reset
        pref_tid = 1'b1;
        step(1'b0, 1'b0, '0, 1'b0, '0, 2'b11);
        chk("R1", "act_tid", act_tid, 1);
        step(1'b1, 1'b1, 1'b1, 1'b0, '0, 2'b11);
        chk("R2", "act_tid", act_tid, 0);
        // Random phase
        for (int i = 0; i < 4000; i++) begin
            logic rn;
            rn = ($urandom_range(0, 199) != 0);
            if (!rn) pref_tid = TW'($urandom_range(0, 1));
            step(rn, ($urandom_range(0, 3) == 0), TW'($urandom_range(0, 1)),
                 ($urandom_range(0, 3) == 0), TW'($urandom_range(0, 1)),
                 ($urandom_range(0, 7) == 0) ? NTHR'($urandom_range(0, 3)) : 2'b11);
            cmp_all(rn ? "R2" : "R1");
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                bad++; total++;
                $display("FAIL watchdog expired actual=hang expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule